// File: doc/BRIEF.md
# Command-Controlled Serial Transceiver

This block is an asynchronous serial transmitter and receiver run from an 8-bit command register. Software uses a small register bus with three addresses. Address 0 takes a byte to transmit on write and returns the received byte on read. Address 1 returns status. Address 2 holds the command register. The command byte sets the parity style, the transmitter state, a break condition, an echo loop and interrupt gating. It also drives two active-low handshake outputs directly: one for request-to-send and one for terminal-ready.

Bit timing comes from an external strobe, `baud_tick`, that pulses once per sixteenth of a bit. A character is always 8 data bits with one stop bit. An optional parity bit sits between the data and the stop bit. An active-low interrupt line reports a full receive buffer, an empty transmit holding register, or both, as the command register allows.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0x00, status reads 0x10, and txd, rts_n, dtr_n and irq_n are all high.
- R2: A frame is a start bit (0), then 8 data bits with the least significant bit first, then the parity bit if enabled, then a stop bit (1). Each bit lasts 16 baud ticks. A received byte reads back unchanged at address 0.
- R3: Command bits 7:5 set parity. If bit 5 is 0 there is no parity bit. 001 gives odd parity and 011 gives even parity. 101 always sends a 1 and 111 always sends a 0. Only the odd and even modes check received parity, and a mismatch sets status bit 0.
- R4: With command bits 3:2 = 00, rts_n is high and the transmitter is off. A written byte stays pending, so status bit 4 reads 0 and txd stays high. No transmit interrupt is raised.
- R5: With bits 3:2 = 01, rts_n is low and the transmitter sends. irq_n goes low while the holding register is empty (status bit 4 = 1).
- R6: With bits 3:2 = 10, rts_n is low and the transmitter sends, but an empty holding register does not raise irq_n.
- R7: With bits 3:2 = 11, rts_n is low, txd is held at 0 for the whole time, and no transmit interrupt is raised.
- R8: With command bit 4 = 1 and bits 3:2 = 00, each received byte is sent back out on txd in the current parity mode.
- R9: With command bit 1 = 0, a full receive buffer (status bit 3) drives irq_n low. With bit 1 = 1 it does not.
- R10: With command bit 0 = 0, dtr_n is high, incoming frames are ignored, and irq_n stays high. With bit 0 = 1, dtr_n is low.
- R11: A stop bit received as 0 sets status bit 1. A byte that arrives while status bit 3 is already set sets status bit 2 and is discarded. Reading address 0 clears status bits 3:0.
- R12: Address 2 reads back the last value written to the command register, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 clears the receive status) |
| reg_addr | input | 2 | Register address: 0 data, 1 status, 2 command |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, registered |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low terminal-ready |
| irq_n | output | 1 | Active-low interrupt, registered |

## Verification
Each output has a fixed latency, and the checks are timed to it:
- irq_n and txd are registered, so a change of command or status shows on them one clock later. The bench waits three clocks before it samples them.
- Receive status is set near the middle of the stop bit. The bench reads status eight clocks after it finishes driving a whole frame.
- Transmitted frames are sampled from the detected start edge: 32 clocks after the edge, then every 64 clocks (16 ticks of 4 clocks). This lands near each bit centre, whatever phase the tick strobe had when transmission began.

All inputs are driven and all outputs sampled on falling clock edges. The bench sweeps every parity mode over several data bytes in both directions.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CMD  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // Parity bit for a byte; sel = command bits 7:6
  // 00 odd, 01 even, 10 forced one, 11 forced zero
  function automatic logic par_bit(input logic [1:0] sel, input logic [BYTE_W-1:0] d);
    case (sel)
      2'b00:   par_bit = ~^d;
      2'b01:   par_bit = ^d;
      2'b10:   par_bit = 1'b1;
      default: par_bit = 1'b0;
    endcase
  endfunction

  // Received parity is compared only in odd or even mode
  function automatic logic par_checked(input logic [2:0] pm);
    par_checked = pm[0] && !pm[2];
  endfunction
endpackage

// File: rtl/uart_cmd_tx.sv
module uart_cmd_tx
  import uart_cmd_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [BYTE_W-1:0] data,
  input  logic              pen,
  input  logic              pbit,
  output logic              line,
  output logic              busy
);
  localparam int FW = BYTE_W + 3;
  localparam int LW = $clog2(FW + 1);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [FW-1:0] frame_q;
  logic [LW-1:0] left_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      cnt_q   <= '0;
      busy    <= 1'b0;
    end else if (start) begin
      frame_q <= {1'b1, (pen ? pbit : 1'b1), data, 1'b0};
      left_q  <= pen ? LW'(FW) : LW'(FW - 1);
      cnt_q   <= '0;
      busy    <= 1'b1;
    end else if (busy && tick) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        frame_q <= {1'b1, frame_q[FW-1:1]};
        left_q  <= left_q - 1'b1;
        if (left_q == LW'(1)) busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line = busy ? frame_q[0] : 1'b1;

  // R2: a start request is followed by the start bit on the line
  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !line));
  // R2: no new frame is requested while one is being shifted out
  p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/uart_cmd_rx.sv
module uart_cmd_rx
  import uart_cmd_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd,
  input  logic              pen,
  input  logic              chk_en,
  input  logic [1:0]        psel,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int NB = BYTE_W + 1;
  localparam int IW = $clog2(NB + 1);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

  rx_st_e        st_q;
  logic [2:0]    sync_q;
  logic [NB-1:0] sh_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic          rxd_s, fall;
  logic [IW-1:0] nbits;

  assign rxd_s = sync_q[1];
  assign fall  = !sync_q[1] && sync_q[2];
  assign nbits = pen ? IW'(NB) : IW'(BYTE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      st_q   <= RX_IDLE;
      sh_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      done   <= 1'b0;
      data   <= '0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], rxd};
      done   <= 1'b0;
      if (!en) begin
        st_q <= RX_IDLE;
      end else begin
        case (st_q)
          RX_IDLE: if (fall) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
          RX_START: if (tick) begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= rxd_s ? RX_IDLE : RX_BITS;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: if (tick) begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              if (idx_q < nbits) begin
                sh_q[idx_q] <= rxd_s;
                idx_q       <= idx_q + 1'b1;
              end else begin
                done <= 1'b1;
                data <= sh_q[BYTE_W-1:0];
                perr <= chk_en && (sh_q[NB-1] != par_bit(psel, sh_q[BYTE_W-1:0]));
                ferr <= !rxd_s;
                st_q <= RX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R10: a disabled receiver never reports a character
  p_rx_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done);
  // R2: character completion is a single-cycle event
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cmd_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              irq_n
);
  logic [BYTE_W-1:0] cmd_q, hold_q, rbuf_q, echo_q;
  logic hold_full, rdrf, pe_q, fe_q, ovr_q, echo_pend, txd_q, irq_q;

  // Command decode, brought out as named wires
  logic [1:0] txc;
  logic tx_on, brk, txie, echo_on, rx_en, pen, chk_en;
  assign txc     = cmd_q[3:2];
  assign tx_on   = (txc == 2'b01) || (txc == 2'b10);
  assign brk     = (txc == 2'b11);
  assign txie    = (txc == 2'b01);
  assign echo_on = cmd_q[4] && (txc == 2'b00);
  assign rx_en   = cmd_q[0];
  assign pen     = cmd_q[5];
  assign chk_en  = par_checked(cmd_q[7:5]);

  // Bus events
  logic wr_cmd, wr_dat, rd_dat;
  assign wr_cmd = reg_wr && (reg_addr == A_CMD);
  assign wr_dat = reg_wr && (reg_addr == A_DATA);
  assign rd_dat = reg_rd && (reg_addr == A_DATA);

  // Transmit launch
  logic tx_busy, tx_line, tx_start, drain_hold;
  logic [BYTE_W-1:0] tx_data;
  assign tx_start   = !tx_busy && (echo_pend || (hold_full && tx_on));
  assign drain_hold = tx_start && !echo_pend;
  assign tx_data    = echo_pend ? echo_q : hold_q;

  logic rx_done, rx_perr, rx_ferr;
  logic [BYTE_W-1:0] rx_data;

  uart_cmd_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_start),
    .data(tx_data), .pen(pen), .pbit(par_bit(cmd_q[7:6], tx_data)),
    .line(tx_line), .busy(tx_busy)
  );

  uart_cmd_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(baud_tick), .rxd(rxd),
    .pen(pen), .chk_en(chk_en), .psel(cmd_q[7:6]),
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      hold_q    <= '0;
      hold_full <= 1'b0;
      echo_q    <= '0;
      echo_pend <= 1'b0;
      rbuf_q    <= '0;
      rdrf      <= 1'b0;
      pe_q      <= 1'b0;
      fe_q      <= 1'b0;
      ovr_q     <= 1'b0;
      txd_q     <= 1'b1;
      irq_q     <= 1'b1;
    end else begin
      if (wr_cmd) cmd_q <= reg_wdata;

      if (wr_dat) begin
        hold_q    <= reg_wdata;
        hold_full <= 1'b1;
      end else if (drain_hold) begin
        hold_full <= 1'b0;
      end

      if (rx_done && echo_on) begin
        echo_q    <= rx_data;
        echo_pend <= 1'b1;
      end else if (tx_start) begin
        echo_pend <= 1'b0;
      end

      if (rx_done) begin
        if (rdrf && !rd_dat) begin
          ovr_q <= 1'b1;
        end else begin
          rbuf_q <= rx_data;
          rdrf   <= 1'b1;
          pe_q   <= rx_perr;
          fe_q   <= rx_ferr;
          ovr_q  <= 1'b0;
        end
      end else if (rd_dat) begin
        rdrf  <= 1'b0;
        pe_q  <= 1'b0;
        fe_q  <= 1'b0;
        ovr_q <= 1'b0;
      end

      txd_q <= brk ? 1'b0 : tx_line;
      irq_q <= !(rx_en && ((!cmd_q[1] && rdrf) || (txie && !hold_full)));
    end
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rbuf_q;
      A_STAT:  reg_rdata = {3'b000, !hold_full, rdrf, ovr_q, fe_q, pe_q};
      A_CMD:   reg_rdata = cmd_q;
      default: reg_rdata = '0;
    endcase
  end

  assign txd   = txd_q;
  assign irq_n = irq_q;
  assign rts_n = (txc == 2'b00);
  assign dtr_n = !cmd_q[0];

  // R4: with the transmitter off a pending byte is never consumed
  p_txoff_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_on && hold_full) |=> hold_full);
  // R7: break state forces the line low on the next cycle
  p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd);
  // R10: receiver disabled keeps the interrupt released
  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> irq_n);
  // R11: a character landing on a full, unread buffer flags overrun
  p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rdrf && !rd_dat) |=> ovr_q);
endmodule

// File: tb/uart_cmd_ctrl_bench.sv
module uart_cmd_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic rxd = 1'b1;
  logic txd, rts_n, dtr_n, irq_n;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  uart_cmd_ctrl u_uart_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .rts_n(rts_n), .dtr_n(dtr_n), .irq_n(irq_n)
  );

  always #5 clk = ~clk;

  // One tick every 4 clocks: a bit is 64 clocks
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      baud_tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic exp_par(input logic [7:0] d, input int pm);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    case (pm)
      1: return (ones % 2 == 0);
      3: return (ones % 2 == 1);
      5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input int pm);
    if (pm % 2 == 1) return {1'b1, exp_par(d, pm), d, 1'b0};
    return {2'b11, d, 1'b0};
  endfunction

  task automatic cap_frame(input int nb, output logic [10:0] f);
    int w = 0;
    f = '1;
    while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
    if (w >= 3000) return;
    repeat (32) @(negedge clk);
    f[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (64) @(negedge clk);
      f[i] = txd;
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pen, input bit pb, input bit stopb);
    @(negedge clk);
    rxd = 1'b0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (64) @(negedge clk); end
    if (pen) begin rxd = pb; repeat (64) @(negedge clk); end
    rxd = stopb;
    repeat (64) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic count_txd(input int n, input logic v, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (txd == v) cnt++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [10:0] f;
    int cnt;
    int pms[5] = '{0, 1, 3, 5, 7};
    logic [7:0] bytes[4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd2, d); chk("R1 cmd", d, 8'h00);
    rd(2'd1, d); chk("R1 status", d, 8'h10);
    chk("R1 pins", {txd, rts_n, dtr_n, irq_n}, 4'hF);

    // R12 readback
    wr(2'd2, 8'hE0); rd(2'd2, d); chk("R12 cmd readback", d, 8'hE0);
    rd(2'd3, d); chk("R12 unused addr", d, 8'h00);

    // R4 transmitter off holds the byte
    wr(2'd2, 8'h01); wr(2'd0, 8'h55);
    count_txd(300, 1'b0, cnt); chk("R4 txd idle", cnt, 0);
    rd(2'd1, d); chk("R4 tdre", d[4], 0);
    chk("R4 rts_n", rts_n, 1); chk("R4 irq_n", irq_n, 1);
    wr(2'd2, 8'h0B);
    cap_frame(10, f); chk("R2 held byte frame", f, exp_frame(8'h55, 0));
    repeat (40) @(negedge clk);

    // R2/R3 transmit sweep over parity modes
    foreach (pms[m]) begin
      wr(2'd2, 8'((pms[m] << 5) | 8'h0B));
      foreach (bytes[b]) begin
        wr(2'd0, bytes[b]);
        cap_frame((pms[m] % 2 == 1) ? 11 : 10, f);
        chk($sformatf("R3 tx pm%0d byte %0h", pms[m], bytes[b]), f, exp_frame(bytes[b], pms[m]));
        repeat (40) @(negedge clk);
      end
    end

    // R5 transmit interrupt
    wr(2'd2, 8'h07);
    repeat (3) @(negedge clk);
    chk("R5 irq on empty", irq_n, 0); chk("R5 rts_n", rts_n, 0);
    wr(2'd0, 8'h12); wr(2'd0, 8'h34);
    repeat (10) @(negedge clk);
    chk("R5 irq while held", irq_n, 1);
    cap_frame(10, f); chk("R5 frame1", f, exp_frame(8'h12, 0));
    cap_frame(10, f); chk("R5 frame2", f, exp_frame(8'h34, 0));
    repeat (3) @(negedge clk);
    chk("R5 irq after drain", irq_n, 0);
    repeat (40) @(negedge clk);

    // R6 no transmit interrupt
    wr(2'd2, 8'h0B);
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk("R6 tdre", d[4], 1);
    chk("R6 irq_n", irq_n, 1); chk("R6 rts_n", rts_n, 0);

    // R7 break
    wr(2'd2, 8'h0D);
    repeat (3) @(negedge clk);
    count_txd(200, 1'b1, cnt); chk("R7 txd low", cnt, 0);
    chk("R7 rts_n", rts_n, 0); chk("R7 irq_n", irq_n, 1);
    wr(2'd2, 8'h0B);
    repeat (3) @(negedge clk);
    chk("R7 release", txd, 1);

    // R2/R3/R9/R11 receive sweep
    foreach (pms[m]) begin
      wr(2'd2, 8'((pms[m] << 5) | 8'h09));
      foreach (bytes[b]) begin
        send_frame(bytes[b], pms[m] % 2, exp_par(bytes[b], pms[m]), 1'b1);
        repeat (8) @(negedge clk);
        rd(2'd1, d); chk($sformatf("R3 rx status pm%0d", pms[m]), d, 8'h18);
        chk("R9 irq on full", irq_n, 0);
        rd(2'd0, d); chk("R2 rx data", d, bytes[b]);
        rd(2'd1, d); chk("R11 cleared", d, 8'h10);
      end
    end

    // R3 parity error in odd mode, ignored in forced-one mode
    wr(2'd2, 8'h29);
    send_frame(8'h01, 1, 1'b1, 1'b1); repeat (8) @(negedge clk);
    rd(2'd1, d); chk("R3 parity error", d, 8'h19); rd(2'd0, d);
    wr(2'd2, 8'hA9);
    send_frame(8'h01, 1, 1'b0, 1'b1); repeat (8) @(negedge clk);
    rd(2'd1, d); chk("R3 forced-one unchecked", d, 8'h18); rd(2'd0, d);

    // R11 framing error
    wr(2'd2, 8'h09);
    send_frame(8'h5A, 0, 1'b0, 1'b0); repeat (8) @(negedge clk);
    rd(2'd1, d); chk("R11 framing", d, 8'h1A); rd(2'd0, d);
    repeat (100) @(negedge clk);

    // R11 overrun
    send_frame(8'h11, 0, 1'b0, 1'b1);
    send_frame(8'h22, 0, 1'b0, 1'b1); repeat (8) @(negedge clk);
    rd(2'd1, d); chk("R11 overrun", d, 8'h1C);
    rd(2'd0, d); chk("R11 first kept", d, 8'h11);
    rd(2'd1, d); chk("R11 overrun cleared", d, 8'h10);

    // R9 receive interrupt blocked
    wr(2'd2, 8'h0B);
    send_frame(8'h33, 0, 1'b0, 1'b1); repeat (8) @(negedge clk);
    chk("R9 irq blocked", irq_n, 1);
    rd(2'd1, d); chk("R9 status", d, 8'h18); rd(2'd0, d);

    // R10 receiver and interrupts disabled
    wr(2'd2, 8'h08);
    send_frame(8'h44, 0, 1'b0, 1'b1); repeat (8) @(negedge clk);
    rd(2'd1, d); chk("R10 frame ignored", d, 8'h10);
    chk("R10 dtr_n high", dtr_n, 1);
    wr(2'd2, 8'h04); repeat (3) @(negedge clk);
    chk("R10 irq masked", irq_n, 1);
    wr(2'd2, 8'h05); repeat (3) @(negedge clk);
    chk("R10 irq unmasked", irq_n, 0); chk("R10 dtr_n low", dtr_n, 0);

    // R8 echo
    wr(2'd2, 8'h11);
    fork
      send_frame(8'h6B, 0, 1'b0, 1'b1);
      cap_frame(10, f);
    join
    chk("R8 echo frame", f, exp_frame(8'h6B, 0));
    rd(2'd0, d); chk("R8 echo data kept", d, 8'h6B);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule